// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is the target side of an I2C link in front of an on-chip byte array that behaves like a two-wire serial EEPROM. It oversamples SCL and SDA on the system clock and finds START, repeated START and STOP conditions. It answers one fixed 7-bit device address. It accepts a two-byte memory address, stores page writes, and serves current-address, random-address and sequential reads. SDA is driven open-drain through an output-enable: the pad pulls low while `sda_oe` is high.

A single address counter serves every transfer. On reads it steps through the whole array and rolls over from the top address to zero. On writes only the low in-page bits advance, so a burst that is longer than the room left in the page folds back to the start of the same page. The full part has a 14-bit counter (`AW = 14`, 16384 bytes). The default parameter value is smaller so that the array stays light when the block is elaborated on its own. A write-protect input is sampled on the rising SCL edge of each write-data acknowledge. While it is high, data bytes are still acknowledged but are not stored.

Top module: `i2c_eeprom_target`

## Requirements
- R1: Out of reset and whenever no transfer is addressed to the block, `sda_oe` is 0; it changes only while the synchronised SCL is low.
- R2: The first byte after a START is acknowledged only when its upper seven bits equal `DEV_ADDR`; any other value gets no acknowledge, and SDA stays released until the next START.
- R3: A write header (LSB 0) is followed by two address bytes, high byte first; the low `AW` bits of these 16 bits load the counter, and the bits above are ignored.
- R4: Each write data byte is acknowledged and stored at the counter; the counter then advances only in its low `PW` bits (page of 2**PW bytes, 64 by default), wrapping inside the page.
- R5: When `wp_i` is 1 at the acknowledge of a write data byte, the array is left unchanged, the byte is still acknowledged, and the counter still advances.
- R6: A read header (LSB 1) that is not preceded by an address phase returns the byte at the current counter value straight away.
- R7: A write header and two address bytes followed by a repeated START and a read header return the byte at the supplied address.
- R8: After each read byte that the master acknowledges, the next address is sent; the counter crosses page boundaries and wraps from address 2**AW-1 to 0.
- R9: After a read byte that the master does not acknowledge, SDA is released and the block ignores SCL activity until a new START.
- R10: A START or STOP in the middle of a data byte ends the transfer; the partial byte is neither stored nor counted.
- R11: A STOP straight after the two address bytes loads the counter and leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND bus) |
| wp_i | input | 1 | Write protect; 1 blocks array updates |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge or a 0 data bit) |

## Verification
The bench aims at the two different wrap rules. A burst that starts two bytes before a page end must fold back to the page base without touching the next page. A sequential read from the same spot must run on into the next page and wrap from the top address to zero. A design that shared one wrap rule would corrupt the neighbour page or read the wrong bytes. Protected writes, a STOP after the address bytes only, and START or STOP in the middle of a byte are each checked through a later current-address read. That read shows whether the counter advanced or the array changed when it should not have. A foreign device address, and bare SCL pulses after a read that ended with no acknowledge, are checked to leave SDA untouched.

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int AW = 11,
  parameter int PW = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_oe
);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [2:0] {IDLE, DEV, AHI, ALO, WDAT, RDAT} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic scl_q, sda_q;
  st_t state;
  logic [3:0] bitc;
  logic [7:0] sh, ahi, tx;
  logic [AW-1:0] addr;
  logic ackd, rw, mack;
  logic [7:0] mem [DEPTH];

  wire scl_s = scl_sy[1];
  wire sda_s = sda_sy[1];
  wire start = scl_s & scl_q & sda_q & ~sda_s;
  wire stop  = scl_s & scl_q & ~sda_q & sda_s;
  wire rise  = scl_s & ~scl_q;
  wire fall  = ~scl_s & scl_q;
  wire [7:0] rx = {sh[6:0], sda_s};
  wire [15:0] full_addr = {ahi, rx};
  wire [AW-1:0] addr_pg = {addr[AW-1:PW], addr[PW-1:0] + 1'b1};

  wire busy    = (state != IDLE) && !start && !stop;
  wire wr_step = busy && rise && state == WDAT && bitc == 4'd8;
  wire rd_step = busy && fall && bitc == 4'd9 &&
                 ((state == DEV && rw) || (state == RDAT && mack));
  wire in_idle = state == IDLE;
  wire rd_ack_slot = state == RDAT && bitc == 4'd9;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end

  always_ff @(posedge clk)
    if (wr_step && !wp_i) mem[addr] <= sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state  <= IDLE;
      bitc   <= '0;
      sh     <= '0;
      ahi    <= '0;
      tx     <= '0;
      addr   <= '0;
      ackd   <= 1'b0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start) begin
      state  <= DEV;
      bitc   <= '0;
      sda_oe <= 1'b0;
    end else if (stop) begin
      state  <= IDLE;
      sda_oe <= 1'b0;
    end else if (state != IDLE) begin
      if (rise) begin
        if (bitc < 4'd8) begin
          sh   <= rx;
          bitc <= bitc + 4'd1;
          if (bitc == 4'd7) begin
            ackd <= 1'b1;
            case (state)
              DEV: begin
                ackd <= rx[7:1] == DEV_ADDR;
                rw   <= rx[0];
                if (rx[7:1] != DEV_ADDR) state <= IDLE;
              end
              AHI:     ahi  <= rx;
              ALO:     addr <= full_addr[AW-1:0];
              default: ;
            endcase
          end
        end else if (bitc == 4'd8) begin
          bitc <= 4'd9;
          mack <= ~sda_s;
          if (state == WDAT) addr <= addr_pg;
        end
      end else if (fall) begin
        if (bitc == 4'd8) begin
          sda_oe <= (state != RDAT) && ackd;
        end else if (bitc == 4'd9) begin
          bitc   <= '0;
          sda_oe <= 1'b0;
          case (state)
            DEV:     state <= rw ? RDAT : AHI;
            AHI:     state <= ALO;
            ALO:     state <= WDAT;
            RDAT:    if (!mack) state <= IDLE;
            default: ;
          endcase
          if (rd_step) begin
            state  <= RDAT;
            tx     <= mem[addr];
            sda_oe <= ~mem[addr][7];
            addr   <= addr + 1'b1;
          end
        end else if (state == RDAT && bitc != 4'd0) begin
          tx     <= {tx[6:0], 1'b0};
          sda_oe <= ~tx[6];
        end
      end
    end
endmodule

// File: rtl/i2c_eeprom_target_chk.sv
module i2c_eeprom_target_chk #(
  parameter int AW = 11,
  parameter int PW = 6
) (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_oe,
  input logic in_idle,
  input logic wr_step,
  input logic rd_step,
  input logic rd_ack_slot,
  input logic [AW-1:0] addr
);
  a_r1_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_oe);

  a_r1_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));

  a_r4_page_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wr_step |=> (addr[AW-1:PW] == $past(addr[AW-1:PW])) &&
                (addr[PW-1:0] == PW'($past(addr[PW-1:0]) + 1'b1)));

  a_r8_read_advance: assert property (@(posedge clk) disable iff (!rst_n)
    rd_step |=> addr == AW'($past(addr) + 1'b1));

  a_r9_master_ack_free: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack_slot |-> !sda_oe);
endmodule

bind i2c_eeprom_target i2c_eeprom_target_chk #(.AW(AW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .in_idle(in_idle), .wr_step(wr_step), .rd_step(rd_step),
  .rd_ack_slot(rd_ack_slot), .addr(addr)
);

// File: tb/i2c_eeprom_target_tb.sv
module i2c_eeprom_target_tb;
  localparam int TB_AW = 11;
  localparam logic [6:0] DEV = 7'h50;
  localparam logic [15:0] AMASK = 16'((1 << TB_AW) - 1);

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1, wp = 1'b0;
  logic sda_oe;
  wire sda_bus = m_sda & ~sda_oe;
  int nchk = 0, nerr = 0;
  bit done = 1'b0;
  logic [7:0] rbuf [0:7];

  always #4 clk = ~clk;

  i2c_eeprom_target #(.DEV_ADDR(DEV), .AW(TB_AW), .PW(6)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .wp_i(wp), .sda_oe(sda_oe));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic q(); repeat (10) @(negedge clk); endtask
  task automatic m_start(); m_sda = 1; q(); m_scl = 1; q(); m_sda = 0; q(); m_scl = 0; q(); endtask
  task automatic m_stop(); m_sda = 0; q(); m_scl = 1; q(); m_sda = 1; q(); endtask
  task automatic bit_w(input logic b); m_sda = b; q(); m_scl = 1; q(); q(); m_scl = 0; q(); endtask
  task automatic bit_r(output logic b); m_sda = 1; q(); m_scl = 1; q(); b = sda_bus; q(); m_scl = 0; q(); endtask

  task automatic send(input logic [7:0] d, output bit ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_w(d[i]);
    bit_r(a);
    ack = !a;
  endtask

  task automatic recv(input bit ack_it, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) bit_r(d[i]);
    bit_w(!ack_it);
  endtask

  task automatic hdr(input logic [15:0] a, output bit ok);
    bit a0, a1, a2;
    m_start();
    send({DEV, 1'b0}, a0); send(a[15:8], a1); send(a[7:0], a2);
    ok = a0 && a1 && a2;
  endtask

  task automatic wr(input logic [15:0] a, input int n, input logic [7:0] d0, input int step,
                    input string tag);
    bit ok, ak;
    hdr(a, ok);
    for (int i = 0; i < n; i++) begin
      send(8'(d0 + i * step), ak);
      ok = ok && ak;
    end
    m_stop();
    check(ok, tag, ok, 1);
  endtask

  task automatic rd_rand(input logic [15:0] a, input int n);
    bit ok, ak;
    hdr(a, ok);
    m_start();
    send({DEV, 1'b1}, ak);
    for (int i = 0; i < n; i++) recv(i < n - 1, rbuf[i]);
    m_stop();
    check(ok && ak, "R7 header acks", ok && ak, 1);
  endtask

  task automatic rd_cur(input int n);
    bit ak;
    m_start();
    send({DEV, 1'b1}, ak);
    for (int i = 0; i < n; i++) recv(i < n - 1, rbuf[i]);
    m_stop();
    check(ak, "R6 read header ack", ak, 1);
  endtask

  task automatic t_reset();
    check(sda_oe == 1'b0, "R1 reset release", sda_oe, 0);
  endtask

  task automatic t_wrong_dev();
    bit ak;
    m_start();
    send(8'h46, ak);
    check(!ak, "R2 foreign address acked", ak, 0);
    send(8'h00, ak);
    check(!ak, "R2 bus touched after mismatch", ak, 0);
    m_stop();
  endtask

  task automatic t_write_read();
    wr(16'h0123, 3, 8'h5A, 17, "R4 write acks");
    rd_rand(16'h0123, 3);
    for (int i = 0; i < 3; i++)
      check(rbuf[i] == 8'(8'h5A + i * 17), "R7 random/R8 sequential data", rbuf[i], 8'(8'h5A + i * 17));
  endtask

  task automatic t_high_bits();
    wr(16'hFA10, 2, 8'hC5, 8'h75, "R3 write acks");
    rd_rand(16'hFA10 & AMASK, 1);
    check(rbuf[0] == 8'hC5, "R3 upper bits ignored", rbuf[0], 8'hC5);
    rd_cur(1);
    check(rbuf[0] == 8'h3A, "R6 current read", rbuf[0], 8'h3A);
  endtask

  task automatic t_page_wrap();
    wr(16'h00C0, 1, 8'h55, 0, "R4 setup");
    wr(16'h00BE, 4, 8'hA0, 1, "R4 page burst acks");
    rd_rand(16'h00BE, 3);
    check(rbuf[0] == 8'hA0, "R4 page byte 62", rbuf[0], 8'hA0);
    check(rbuf[1] == 8'hA1, "R4 page byte 63", rbuf[1], 8'hA1);
    check(rbuf[2] == 8'h55, "R8 read crosses page / R4 next page untouched", rbuf[2], 8'h55);
    rd_rand(16'h0080, 2);
    check(rbuf[0] == 8'hA2 && rbuf[1] == 8'hA3, "R4 wrap to page base",
          {rbuf[0], rbuf[1]}, 16'hA2A3);
  endtask

  task automatic t_end_wrap();
    wr(AMASK, 1, 8'hE7, 0, "R8 setup top");
    wr(16'h0000, 1, 8'h19, 0, "R8 setup zero");
    rd_rand(AMASK, 2);
    check(rbuf[0] == 8'hE7, "R8 top byte", rbuf[0], 8'hE7);
    check(rbuf[1] == 8'h19, "R8 wrap to zero", rbuf[1], 8'h19);
  endtask

  task automatic t_wp();
    wr(16'h0300, 2, 8'h11, 8'h11, "R5 setup");
    wp = 1'b1;
    wr(16'h0300, 1, 8'h99, 0, "R5 protected byte still acked");
    wp = 1'b0;
    rd_cur(1);
    check(rbuf[0] == 8'h22, "R5 counter advanced", rbuf[0], 8'h22);
    rd_rand(16'h0300, 1);
    check(rbuf[0] == 8'h11, "R5 array unchanged", rbuf[0], 8'h11);
  endtask

  task automatic t_hdr_stop();
    bit ok;
    wr(16'h0455, 1, 8'h6D, 0, "R11 setup");
    wr(16'h0010, 1, 8'h01, 0, "R11 move counter");
    hdr(16'h0455, ok);
    m_stop();
    check(ok, "R11 header acks", ok, 1);
    rd_cur(1);
    check(rbuf[0] == 8'h6D, "R11 counter loaded, array kept", rbuf[0], 8'h6D);
  endtask

  task automatic t_abort();
    bit ok, ak;
    wr(16'h0500, 1, 8'h42, 0, "R10 setup");
    hdr(16'h0500, ok);
    for (int i = 0; i < 4; i++) bit_w(1'b1);
    m_start();
    send({DEV, 1'b1}, ak);
    recv(1'b0, rbuf[0]);
    m_stop();
    check(rbuf[0] == 8'h42, "R10 START mid-byte", rbuf[0], 8'h42);
    hdr(16'h0500, ok);
    for (int i = 0; i < 3; i++) bit_w(1'b0);
    m_stop();
    rd_cur(1);
    check(rbuf[0] == 8'h42, "R10 STOP mid-byte", rbuf[0], 8'h42);
  endtask

  task automatic t_nack_idle();
    logic b;
    int low = 0;
    rd_rand(16'h0123, 1);
    check(rbuf[0] == 8'h5A, "R9 single read", rbuf[0], 8'h5A);
    for (int i = 0; i < 9; i++) begin
      bit_r(b);
      if (!b) low++;
    end
    check(low == 0, "R9 idle after no-ack", low, 0);
    rd_cur(1);
    check(rbuf[0] == 8'h5A + 8'd17, "R9 next transfer works", rbuf[0], 8'h5A + 8'd17);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    q();
    t_reset();
    t_wrong_dev();
    t_write_read();
    t_high_bits();
    t_page_wrap();
    t_end_wrap();
    t_wp();
    t_hdr_stop();
    t_abort();
    t_nack_idle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule